// File: doc/BRIEF.md
# External Interrupt and Event Controller

This block turns edges on a bank of general-purpose input pins into per-line interrupt requests and per-line event pulses. There are 16 lines and 7 input ports. Line n can only be fed by pin n of one of the ports, and a per-line source field picks which port that is. Every line has its own rising and falling edge enables and its own software trigger. A trigger feeds two paths that run side by side. The interrupt path sets a sticky pending bit, which is gated by an interrupt mask. The event path is gated by a separate event mask and drives a single-cycle pulse generator.

Software configures the block through a simple word-addressed register port. Writes take effect on the clock edge where `bus_we` is high. Reads are combinational from `bus_addr`. The pending register is cleared by writing ones to it. Each pin goes through a two-flop synchroniser before edge detection. A pin change therefore reaches the pending bit and the event output on the third rising clock edge after the pin changes.

Register map, by word address:

| Address | Contents |
|---|---|
| 0 | interrupt mask |
| 1 | event mask |
| 2 | rising-edge enable |
| 3 | falling-edge enable |
| 4 | software trigger (write one to set) |
| 5 | pending (write one to clear) |
| 6 | source fields for lines 0 to 7 |
| 7 | source fields for lines 8 to 15 |

In addresses 0 to 5, bit n belongs to line n. In addresses 6 and 7, line k of the word has a 4-bit field at bits [4k+3:4k]. All other addresses read as zero.

Top module: `irq_evt_ctrl`

## Requirements
- R1: The 4-bit source field of line n selects port p when its value p is 0 to 6. The line then follows pin input bit p*16+n, and pin n of every other port has no effect on that line. A field value of 7 to 15 connects no port, and the line never triggers from pins.
- R2: A low-to-high change on a line's selected pin triggers the line when its rising enable bit is set. A high-to-low change triggers it when its falling enable bit is set. With both bits set, both changes trigger. The resulting pending bit and event pulse appear on the third rising clock edge after the pin changes.
- R3: Writing a one to a bit of the software trigger register (address 4) sets that bit. The line's pending bit becomes set on the following edge, with a single event pulse. The software trigger bit clears itself when that line's pending bit is cleared. If a set and a clear of the same line land in one write cycle, the clear wins.
- R4: A pending bit, once set, stays set until a one is written to its position at address 5. Writing zeros has no effect. If a hardware trigger and a clear of the same line land in the same cycle, the bit stays set.
- R5: irq_o[n] is high exactly when pending bit n and interrupt mask bit n are both set. A pending bit stays pending while it is masked, and the request appears as soon as the mask bit is set.
- R6: evt_o[n] gives a pulse exactly one clock cycle wide on the edge after line n's trigger goes active, but only if event mask bit n is set. A trigger that stays active gives no further pulse. The event mask has no effect on the pending bit.
- R7: Registers at addresses 0 to 7 read back the values last written to them (pending and software trigger show their current state). Other addresses read as zero.
- R8: After reset, all registers read zero, and irq_o and evt_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |
| pins_i | input | 112 | Pin inputs, port p pin n at bit p*16+n |
| irq_o | output | 16 | Per-line interrupt request |
| evt_o | output | 16 | Per-line one-cycle event pulse |

## Verification
A wrong source select, synchroniser or edge detector shows up at the ports as a missing or extra pending bit and event pulse, or as one that arrives on the wrong edge. The bench compares irq_o and evt_o against a cycle-level reference on every clock, so such an error is seen within three cycles of the offending pin change. A damaged pending latch or software trigger bit shows on irq_o as soon as the mask is open. It also shows on readback of addresses 4 and 5, which the bench performs after random traffic.

// File: rtl/irq_evt_pkg.sv
package irq_evt_pkg;

    localparam int LINES   = 16;
    localparam int PORTS   = 7;
    localparam int FIELD_W = 4;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 4;
    localparam int FIELDS_PER_WORD = DATA_W / FIELD_W;
    localparam int SEL_WORDS = (LINES + FIELDS_PER_WORD - 1) / FIELDS_PER_WORD;

    typedef enum logic [ADDR_W-1:0] {
        A_IMASK = 4'h0,
        A_EMASK = 4'h1,
        A_RISE  = 4'h2,
        A_FALL  = 4'h3,
        A_SWTRG = 4'h4,
        A_PEND  = 4'h5,
        A_SEL0  = 4'h6
    } reg_addr_e;

    typedef struct packed {
        logic [LINES-1:0] imask;
        logic [LINES-1:0] emask;
        logic [LINES-1:0] rise;
        logic [LINES-1:0] fall;
    } line_cfg_t;

    function automatic logic [ADDR_W-1:0] sel_word_addr(input int w);
        return ADDR_W'(int'(A_SEL0) + w);
    endfunction

endpackage

// File: rtl/iec_regs.sv
module iec_regs
    import irq_evt_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wdata,
    output logic [DATA_W-1:0]        rdata,
    input  logic [LINES-1:0]         pend_i,
    output line_cfg_t                cfg_o,
    output logic [LINES*FIELD_W-1:0] sel_o,
    output logic [LINES-1:0]         sw_o,
    output logic [LINES-1:0]         clr_o
);
    line_cfg_t            cfg_q;
    logic [LINES-1:0]     sw_q;
    logic [FIELD_W-1:0]   sel_q [LINES];
    logic [LINES-1:0]     set_v;
    logic [LINES-1:0]     clr_v;

    assign set_v = (we && addr == A_SWTRG) ? wdata[LINES-1:0] : '0;
    assign clr_v = (we && addr == A_PEND)  ? wdata[LINES-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            sw_q  <= '0;
            for (int n = 0; n < LINES; n++) sel_q[n] <= '0;
        end else begin
            sw_q <= (sw_q | set_v) & ~clr_v;
            if (we) begin
                case (addr)
                    A_IMASK: cfg_q.imask <= wdata[LINES-1:0];
                    A_EMASK: cfg_q.emask <= wdata[LINES-1:0];
                    A_RISE:  cfg_q.rise  <= wdata[LINES-1:0];
                    A_FALL:  cfg_q.fall  <= wdata[LINES-1:0];
                    default: ;
                endcase
                for (int w = 0; w < SEL_WORDS; w++) begin
                    if (addr == sel_word_addr(w)) begin
                        for (int f = 0; f < FIELDS_PER_WORD; f++) begin
                            if (w*FIELDS_PER_WORD + f < LINES)
                                sel_q[w*FIELDS_PER_WORD + f] <= wdata[f*FIELD_W +: FIELD_W];
                        end
                    end
                end
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_IMASK: rdata[LINES-1:0] = cfg_q.imask;
            A_EMASK: rdata[LINES-1:0] = cfg_q.emask;
            A_RISE:  rdata[LINES-1:0] = cfg_q.rise;
            A_FALL:  rdata[LINES-1:0] = cfg_q.fall;
            A_SWTRG: rdata[LINES-1:0] = sw_q;
            A_PEND:  rdata[LINES-1:0] = pend_i;
            default: ;
        endcase
        for (int w = 0; w < SEL_WORDS; w++) begin
            if (addr == sel_word_addr(w)) begin
                for (int f = 0; f < FIELDS_PER_WORD; f++) begin
                    if (w*FIELDS_PER_WORD + f < LINES)
                        rdata[f*FIELD_W +: FIELD_W] = sel_q[w*FIELDS_PER_WORD + f];
                end
            end
        end
    end

    generate
        for (genvar n = 0; n < LINES; n++) begin : g_sel_out
            assign sel_o[n*FIELD_W +: FIELD_W] = sel_q[n];
        end
    endgenerate

    assign cfg_o = cfg_q;
    assign sw_o  = sw_q;
    assign clr_o = clr_v;

    AST_SW_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (clr_v != '0) |=> ((sw_q & $past(clr_v)) == '0)); // R3

endmodule

// File: rtl/iec_front.sv
module iec_front
    import irq_evt_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic [PORTS*LINES-1:0]   pins_i,
    input  logic [LINES*FIELD_W-1:0] sel_i,
    input  logic [LINES-1:0]         rise_en_i,
    input  logic [LINES-1:0]         fall_en_i,
    output logic [LINES-1:0]         hw_trig_o
);
    logic [LINES-1:0] line_in;
    logic [LINES-1:0] sync1_q, sync2_q, prev_q;
    logic [LINES-1:0] rise_det, fall_det;

    generate
        for (genvar n = 0; n < LINES; n++) begin : g_src
            logic lv;
            always_comb begin
                lv = 1'b0;
                for (int p = 0; p < PORTS; p++) begin
                    if (sel_i[n*FIELD_W +: FIELD_W] == FIELD_W'(p))
                        lv = pins_i[p*LINES + n];
                end
            end
            assign line_in[n] = lv;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1_q <= '0;
            sync2_q <= '0;
            prev_q  <= '0;
        end else begin
            sync1_q <= line_in;
            sync2_q <= sync1_q;
            prev_q  <= sync2_q;
        end
    end

    assign rise_det  = sync2_q & ~prev_q;
    assign fall_det  = ~sync2_q & prev_q;
    assign hw_trig_o = (rise_det & rise_en_i) | (fall_det & fall_en_i);

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (rise_det != '0) |=> ((rise_det & $past(rise_det)) == '0)); // R2

endmodule

// File: rtl/iec_pend.sv
module iec_pend
    import irq_evt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] hw_trig_i,
    input  logic [LINES-1:0] sw_i,
    input  logic [LINES-1:0] clr_i,
    input  logic [LINES-1:0] imask_i,
    input  logic [LINES-1:0] emask_i,
    output logic [LINES-1:0] pend_o,
    output logic [LINES-1:0] irq_o,
    output logic [LINES-1:0] evt_o
);
    logic [LINES-1:0] pend_q, evt_q, trig_prev_q, trig_all;

    assign trig_all = hw_trig_i | sw_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q      <= '0;
            evt_q       <= '0;
            trig_prev_q <= '0;
        end else begin
            pend_q      <= (pend_q & ~clr_i) | hw_trig_i | (sw_i & ~clr_i);
            evt_q       <= trig_all & emask_i & ~trig_prev_q;
            trig_prev_q <= trig_all;
        end
    end

    assign pend_o = pend_q;
    assign irq_o  = pend_q & imask_i;
    assign evt_o  = evt_q;

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (rst)
        ((pend_q & ~clr_i) != '0) |=> ((pend_q & $past(pend_q & ~clr_i)) == $past(pend_q & ~clr_i))); // R4

    AST_CLR_LOSES: assert property (@(posedge clk) disable iff (rst)
        ((clr_i & hw_trig_i) != '0) |=> ((pend_q & $past(clr_i & hw_trig_i)) == $past(clr_i & hw_trig_i))); // R4

    AST_EVT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (evt_q != '0) |=> ((evt_q & $past(evt_q)) == '0)); // R6

    AST_EVT_MASKED: assert property (@(posedge clk) disable iff (rst)
        (evt_q != '0) |-> ((evt_q & ~$past(emask_i)) == '0)); // R6

endmodule

// File: rtl/irq_evt_ctrl.sv
module irq_evt_ctrl
    import irq_evt_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   bus_we,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [DATA_W-1:0]      bus_wdata,
    output logic [DATA_W-1:0]      bus_rdata,
    input  logic [PORTS*LINES-1:0] pins_i,
    output logic [LINES-1:0]       irq_o,
    output logic [LINES-1:0]       evt_o
);
    line_cfg_t                cfg;
    logic [LINES*FIELD_W-1:0] sel;
    logic [LINES-1:0]         sw, clr, pend, hw_trig;

    iec_regs u_regs (
        .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
        .rdata(bus_rdata), .pend_i(pend), .cfg_o(cfg), .sel_o(sel),
        .sw_o(sw), .clr_o(clr)
    );

    iec_front u_front (
        .clk(clk), .rst(rst), .pins_i(pins_i), .sel_i(sel),
        .rise_en_i(cfg.rise), .fall_en_i(cfg.fall), .hw_trig_o(hw_trig)
    );

    iec_pend u_pend (
        .clk(clk), .rst(rst), .hw_trig_i(hw_trig), .sw_i(sw), .clr_i(clr),
        .imask_i(cfg.imask), .emask_i(cfg.emask),
        .pend_o(pend), .irq_o(irq_o), .evt_o(evt_o)
    );

    AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst)
        ((irq_o & ~pend) == '0)); // R5

endmodule

// File: tb/irq_evt_ctrl_bench.sv
`timescale 1ns/1ps
module irq_evt_ctrl_bench;
    localparam int L = 16;
    localparam int P = 7;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_we = 1'b0;
    logic [3:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [P*L-1:0] pins = '0;
    logic [L-1:0]  irq, evt;

    int tests = 0;
    int fails = 0;
    bit done = 0;
    bit mon_en = 0;

    always #4 clk = ~clk;

    irq_evt_ctrl u_irq_evt_ctrl (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pins_i(pins),
        .irq_o(irq), .evt_o(evt)
    );

    // reference state
    logic [L-1:0] m_imr, m_emr, m_rise, m_fall, m_sw, m_pend, m_evt, m_tp;
    logic [L-1:0] m_s1, m_s2, m_prev;
    logic [3:0]   m_sel [L];

    function automatic logic [L-1:0] src_lines(input logic [P*L-1:0] pv);
        logic [L-1:0] r;
        for (int n = 0; n < L; n++)
            r[n] = (m_sel[n] < 4'(P)) ? pv[int'(m_sel[n])*L + n] : 1'b0;
        return r;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_imr = '0; m_emr = '0; m_rise = '0; m_fall = '0; m_sw = '0;
            m_pend = '0; m_evt = '0; m_tp = '0; m_s1 = '0; m_s2 = '0; m_prev = '0;
            for (int n = 0; n < L; n++) m_sel[n] = '0;
        end else begin
            logic [L-1:0] hw, trig, clr, setv, lin;
            lin  = src_lines(pins);
            hw   = (m_s2 & ~m_prev & m_rise) | (~m_s2 & m_prev & m_fall);
            trig = hw | m_sw;
            clr  = (bus_we && bus_addr == 4'd5) ? bus_wdata[L-1:0] : '0;
            setv = (bus_we && bus_addr == 4'd4) ? bus_wdata[L-1:0] : '0;
            m_pend = (m_pend & ~clr) | hw | (m_sw & ~clr);
            m_evt  = trig & m_emr & ~m_tp;
            m_tp   = trig;
            m_prev = m_s2; m_s2 = m_s1; m_s1 = lin;
            m_sw   = (m_sw | setv) & ~clr;
            if (bus_we) begin
                case (bus_addr)
                    4'd0: m_imr  = bus_wdata[L-1:0];
                    4'd1: m_emr  = bus_wdata[L-1:0];
                    4'd2: m_rise = bus_wdata[L-1:0];
                    4'd3: m_fall = bus_wdata[L-1:0];
                    4'd6: for (int f = 0; f < 8; f++) m_sel[f]   = bus_wdata[f*4 +: 4];
                    4'd7: for (int f = 0; f < 8; f++) m_sel[8+f] = bus_wdata[f*4 +: 4];
                    default: ;
                endcase
            end
        end
    end

    always @(negedge clk) begin
        if (mon_en && !rst) begin
            tests++;
            if (irq !== (m_pend & m_imr)) begin
                fails++;
                $display("FAIL R5 irq actual=%h expected=%h t=%0t", irq, m_pend & m_imr, $time);
            end
            tests++;
            if (evt !== m_evt) begin
                fails++;
                $display("FAIL R6 evt actual=%h expected=%h t=%0t", evt, m_evt, $time);
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_pin(input int port, input int line, input logic v);
        @(negedge clk);
        pins[port*L + line] = v;
    endtask

    initial begin
        logic [31:0] d;
        logic [L-1:0] seen;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R8 reset state
        for (int a = 0; a < 16; a++) begin
            rd(4'(a), d);
            check("R8 reset readback", d, 32'h0);
        end
        check("R8 irq after reset", {16'h0, irq}, 32'h0);
        check("R8 evt after reset", {16'h0, evt}, 32'h0);
        mon_en = 1;

        // R7 readback
        wr(4'd0, 32'h0000_A5A5); rd(4'd0, d); check("R7 imask", d, 32'h0000_A5A5);
        wr(4'd6, 32'h7654_3210); rd(4'd6, d); check("R7 sel lo", d, 32'h7654_3210);
        wr(4'd7, 32'hFEDC_BA98); rd(4'd7, d); check("R7 sel hi", d, 32'hFEDC_BA98);
        rd(4'd9, d); check("R7 unmapped", d, 32'h0);

        // R1: line 4 from port 3, rising edges
        wr(4'd6, 32'h0003_0000); wr(4'd7, 32'h0);
        wr(4'd0, 32'h0000_FFFF); wr(4'd1, 32'h0000_FFFF);
        wr(4'd2, 32'h0000_0010); wr(4'd3, 32'h0);
        set_pin(0, 4, 1'b1); idle(5);
        rd(4'd5, d); check("R1 other port ignored", d, 32'h0);
        set_pin(3, 4, 1'b1); idle(5);
        rd(4'd5, d); check("R1 selected port triggers", d, 32'h0000_0010);
        // R4 sticky and write-zero no effect
        wr(4'd5, 32'h0); idle(3);
        rd(4'd5, d); check("R4 sticky", d, 32'h0000_0010);
        wr(4'd5, 32'h0000_0010); rd(4'd5, d); check("R4 w1c", d, 32'h0);

        // R2: falling only, then both
        wr(4'd2, 32'h0); wr(4'd3, 32'h0000_0010);
        set_pin(3, 4, 1'b0); idle(5);
        rd(4'd5, d); check("R2 falling", d, 32'h0000_0010);
        wr(4'd5, 32'h0000_0010);
        set_pin(3, 4, 1'b1); idle(5);
        rd(4'd5, d); check("R2 rising ignored in falling mode", d, 32'h0);
        wr(4'd2, 32'h0000_0010);
        set_pin(3, 4, 1'b0); idle(5);
        rd(4'd5, d); check("R2 both mode", d, 32'h0000_0010);
        wr(4'd5, 32'h0000_0010);

        // R1 no-source code
        wr(4'd6, 32'h0000_0F00); wr(4'd2, 32'h0000_0004);
        for (int p = 0; p < P; p++) set_pin(p, 2, 1'b1);
        idle(5);
        rd(4'd5, d); check("R1 code 15 no source", d, 32'h0);

        // R5 masked pending then unmask
        wr(4'd0, 32'h0);
        wr(4'd4, 32'h0000_0100); idle(3);
        check("R5 masked irq low", {16'h0, irq}, 32'h0);
        wr(4'd0, 32'h0000_0100); idle(1);
        check("R5 unmasked irq", {16'h0, irq}, 32'h0000_0100);
        // R3 self clear
        wr(4'd5, 32'h0000_0100);
        rd(4'd4, d); check("R3 sw self clear", d, 32'h0);
        rd(4'd5, d); check("R3 pend cleared", d, 32'h0);
        // R6 event masked but pending set
        wr(4'd1, 32'h0);
        seen = '0;
        wr(4'd4, 32'h0000_0200);
        for (int i = 0; i < 4; i++) begin @(negedge clk); seen |= evt; end
        check("R6 event mask blocks pulse", {16'h0, seen}, 32'h0);
        rd(4'd5, d); check("R6 pending despite event mask", d, 32'h0000_0200);
        wr(4'd5, 32'h0000_0200);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            for (int k = 0; k < 6; k++) pins[$urandom_range(P*L-1)] ^= 1'b1;
            if ($urandom_range(9) == 0) begin
                bus_we = 1'b1;
                bus_addr = 4'($urandom_range(7));
                bus_wdata = $urandom();
                if (bus_addr == 4'd4) bus_wdata &= 32'h0000_0101 << $urandom_range(7);
            end else begin
                bus_we = 1'b0;
            end
        end
        @(negedge clk); bus_we = 1'b0;
        rd(4'd5, d); check("R4 random pending", d, {16'h0, m_pend});
        rd(4'd4, d); check("R3 random swtrig", d, {16'h0, m_sw});
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule